// File: doc/BRIEF.md
# Byte-Read Status Silo with Completion Flags

This block holds a short queue of 16-bit status words for a disk controller and hands them to a host that reads one byte at a time. Each read strobe returns one half of the head entry, low half first. After the high half has been read, the queue moves forward by one entry. The last entry keeps its value when it moves forward, so a host that reads past the end keeps getting the final word again. The queue is filled in one of two ways. A drive-status fill copies one word into every entry. A header fill places the packed track/sector word in the head entry and clears the other entries.

The completion flags sit beside the queue. A completion pulse sets done and ORs its error bits into a sticky error register. The error flag is raised whenever that register is nonzero. An interrupt request follows done, gated by an enable bit taken from the command word. The host polls with skip-on-done and skip-on-error strobes, and each answers with a skip and then clears its own flag. Loading a new command word clears done, the error register, the error flag and the byte side pointer. At most one strobe is expected per cycle. When strobes do coincide, a completion pulse overrides the clears, a fill overrides a shift, and a command load overrides a pointer toggle.

Top module: `silo_status`

## Requirements
- R1: While the side pointer is low, a read strobe sees rd_byte_o equal to bits 7:0 of the head entry, and the entries do not change.
- R2: While the side pointer is high, a read strobe sees rd_byte_o equal to bits 15:8 of the head entry. After that edge, entry 0 takes entry 1, entry 1 takes entry 2, and entry 2 keeps its old value.
- R3: The side pointer starts low after reset, toggles on every read strobe, and is forced low by a command load.
- R4: A status fill writes status_word_i into all three entries.
- R5: A header fill writes {cyl_i, head_i, sector_i} into entry 0, which is ((cyl*2+head) << 6) | sector: cylinder in bits 15:7, head in bit 6, sector in bits 5:0. Entries 1 and 2 become zero.
- R6: A completion pulse sets done and ORs done_err_i into the error register. The error flag is then set if the register is nonzero, even when the pulse itself carries no bits.
- R7: irq_o is high exactly when done is set and bit 8 of the last loaded command word is 1.
- R8: During a skip-on-done strobe, skip_done_o equals done. After that edge, done and irq_o are low.
- R9: During a skip-on-error strobe, skip_err_o equals the error flag. After that edge, the flag is low and the error register is unchanged.
- R10: A command load clears done, irq_o, the error register, the error flag and the side pointer.
- R11: err_rd_o shows the error register masked with octal 07003. Bit 0 comes from drive_ready_i alone; bits 11:9 and bit 1 come from the register; all other bits are zero.
- R12: After reset, all entries are zero and done, the error flag, irq_o and the error register are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_load_i | input | 1 | Command word load strobe |
| cmd_word_i | input | 12 | Command word; bit 8 is interrupt enable |
| ld_status_i | input | 1 | Fill all entries with status_word_i |
| status_word_i | input | 16 | Drive status word |
| ld_header_i | input | 1 | Header fill strobe |
| cyl_i | input | 9 | Cylinder for header fill |
| head_i | input | 1 | Head for header fill |
| sector_i | input | 6 | Sector for header fill |
| rd_byte_i | input | 1 | Byte read strobe |
| rd_byte_o | output | 8 | Byte presented for the current read |
| done_pulse_i | input | 1 | Command completion pulse |
| done_err_i | input | 12 | Error bits carried by the completion |
| skip_done_i | input | 1 | Skip-on-done strobe |
| skip_err_i | input | 1 | Skip-on-error strobe |
| drive_ready_i | input | 1 | Selected drive attached and idle |
| skip_done_o | output | 1 | Skip answer to skip-on-done |
| skip_err_o | output | 1 | Skip answer to skip-on-error |
| done_o | output | 1 | Done flag |
| err_flag_o | output | 1 | Error flag |
| irq_o | output | 1 | Interrupt request |
| err_rd_o | output | 12 | Masked error register readback |

## Verification
The byte readout is tested three ways. A status fill followed by more reads than the queue holds shows that the tail entry repeats. A header fill followed by reads shows the zeroed trailing entries and the packed cylinder/head/sector layout. Random mixes of fills, reads and command loads catch a side pointer that is not cleared or a shift that fires on the low half. The flag logic is driven with completions whose error bits are zero as well as nonzero. Running skip-on-error between two completions separates the sticky register from the flag it feeds. Command words with and without the enable bit separate irq_o from done.

// File: rtl/silo_pkg.sv
package silo_pkg;
  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_STATUS = 2'd1,
    FILL_HEADER = 2'd2
  } fill_e;
endpackage

// File: rtl/silo_queue.sv
module silo_queue
  import silo_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  fill_e                      fill_i,
  input  logic [W-1:0]               fill_word_i,
  input  logic                       rd_i,
  input  logic                       side_clr_i,
  output logic [DEPTH-1:0][W-1:0]    ent_o,
  output logic                       side_o,
  output logic [W/2-1:0]             byte_o
);
  localparam int HB = W / 2;

  logic side_q;
  logic pop;

  assign pop    = rd_i & side_q;
  assign side_o = side_q;
  assign byte_o = side_q ? ent_o[0][W-1:HB] : ent_o[0][HB-1:0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] q;
    logic [W-1:0] shift_in;
    if (i == DEPTH - 1) begin : g_tail
      assign shift_in = q;  // tail repeats
    end else begin : g_body
      assign shift_in = ent_o[i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else begin
        unique case (fill_i)
          FILL_STATUS: q <= fill_word_i;
          FILL_HEADER: q <= (i == 0) ? fill_word_i : '0;
          default:     if (pop) q <= shift_in;
        endcase
      end
    end
    assign ent_o[i] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         side_q <= 1'b0;
    else if (side_clr_i) side_q <= 1'b0;
    else if (rd_i)       side_q <= ~side_q;
  end
endmodule

// File: rtl/silo_flags.sv
module silo_flags #(
  parameter int            CMD_W    = 12,
  parameter int            ERR_W    = 12,
  parameter int            IE_BIT   = 8,
  parameter logic [11:0]   ERR_MASK = 12'o7003
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_load_i,
  input  logic [CMD_W-1:0] cmd_word_i,
  input  logic             done_pulse_i,
  input  logic [ERR_W-1:0] done_err_i,
  input  logic             skip_done_i,
  input  logic             skip_err_i,
  input  logic             drive_ready_i,
  output logic             done_o,
  output logic             err_flag_o,
  output logic             irq_o,
  output logic             skip_done_o,
  output logic             skip_err_o,
  output logic [ERR_W-1:0] err_rd_o
);
  localparam logic [ERR_W-1:0] MASK = ERR_W'(ERR_MASK);
  localparam logic [ERR_W-1:0] RDY  = ERR_W'(1);

  logic             done_q, ef_q, ie_q;
  logic [ERR_W-1:0] err_q, err_base, err_next;

  assign err_base = cmd_load_i ? '0 : err_q;
  assign err_next = done_pulse_i ? (err_base | done_err_i) : err_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      ef_q   <= 1'b0;
      ie_q   <= 1'b0;
      err_q  <= '0;
    end else begin
      err_q <= err_next;
      if (cmd_load_i) ie_q <= cmd_word_i[IE_BIT];
      if (done_pulse_i)                    done_q <= 1'b1;
      else if (cmd_load_i || skip_done_i)  done_q <= 1'b0;
      if (done_pulse_i)                    ef_q <= (err_next != '0);
      else if (cmd_load_i || skip_err_i)   ef_q <= 1'b0;
    end
  end

  assign done_o      = done_q;
  assign err_flag_o  = ef_q;
  assign irq_o       = done_q & ie_q;
  assign skip_done_o = skip_done_i & done_q;
  assign skip_err_o  = skip_err_i & ef_q;
  assign err_rd_o    = (err_q & MASK & ~RDY) | (drive_ready_i ? RDY : '0);
endmodule

// File: rtl/silo_status.sv
module silo_status
  import silo_pkg::*;
#(
  parameter int DEPTH  = 3,
  parameter int CYL_W  = 9,
  parameter int SEC_W  = 6,
  parameter int CMD_W  = 12,
  parameter int ERR_W  = 12,
  parameter int IE_BIT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_load_i,
  input  logic [CMD_W-1:0] cmd_word_i,
  input  logic             ld_status_i,
  input  logic [CYL_W+SEC_W:0] status_word_i,
  input  logic             ld_header_i,
  input  logic [CYL_W-1:0] cyl_i,
  input  logic             head_i,
  input  logic [SEC_W-1:0] sector_i,
  input  logic             rd_byte_i,
  output logic [(CYL_W+SEC_W+1)/2-1:0] rd_byte_o,
  input  logic             done_pulse_i,
  input  logic [ERR_W-1:0] done_err_i,
  input  logic             skip_done_i,
  input  logic             skip_err_i,
  input  logic             drive_ready_i,
  output logic             skip_done_o,
  output logic             skip_err_o,
  output logic             done_o,
  output logic             err_flag_o,
  output logic             irq_o,
  output logic [ERR_W-1:0] err_rd_o
);
  localparam int W = CYL_W + SEC_W + 1;

  fill_e                    fill;
  logic [W-1:0]             fill_word;
  logic [DEPTH-1:0][W-1:0]  ent;
  logic                     side;

  always_comb begin
    fill      = FILL_NONE;
    fill_word = status_word_i;
    if (ld_status_i) fill = FILL_STATUS;
    else if (ld_header_i) begin
      fill      = FILL_HEADER;
      fill_word = {cyl_i, head_i, sector_i};  // (cyl*2+head)<<SEC_W | sector
    end
  end

  silo_queue #(.W(W), .DEPTH(DEPTH)) u_q (
    .clk_i, .rst_ni,
    .fill_i      (fill),
    .fill_word_i (fill_word),
    .rd_i        (rd_byte_i),
    .side_clr_i  (cmd_load_i),
    .ent_o       (ent),
    .side_o      (side),
    .byte_o      (rd_byte_o)
  );

  silo_flags #(.CMD_W(CMD_W), .ERR_W(ERR_W), .IE_BIT(IE_BIT)) u_f (
    .clk_i, .rst_ni,
    .cmd_load_i, .cmd_word_i, .done_pulse_i, .done_err_i,
    .skip_done_i, .skip_err_i, .drive_ready_i,
    .done_o, .err_flag_o, .irq_o, .skip_done_o, .skip_err_o, .err_rd_o
  );
endmodule

// File: rtl/silo_status_chk.sv
module silo_status_chk #(
  parameter int DEPTH = 3,
  parameter int W     = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cmd_load_i,
  input logic                    ld_status_i,
  input logic                    ld_header_i,
  input logic [W-1:0]            status_word_i,
  input logic                    rd_byte_i,
  input logic                    done_pulse_i,
  input logic                    skip_done_i,
  input logic                    done_o,
  input logic                    err_flag_o,
  input logic                    irq_o,
  input logic                    side,
  input logic [DEPTH-1:0][W-1:0] ent
);
  logic no_fill;
  assign no_fill = !ld_status_i && !ld_header_i;

  p_low_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_byte_i && !side && no_fill |=> $stable(ent));
  p_high_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_byte_i && side && no_fill |=>
      ent[0] == $past(ent[1]) && ent[DEPTH-1] == $past(ent[DEPTH-1]));
  p_side_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_byte_i && !cmd_load_i |=> side != $past(side));
  p_status_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_status_i |=> ent[0] == $past(status_word_i) && ent[1] == ent[0] && ent[2] == ent[0]);
  p_header_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_header_i && !ld_status_i |=> ent[1] == '0 && ent[2] == '0);
  p_done_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse_i |=> done_o);
  p_irq_needs_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);
  p_skip_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_done_i && !done_pulse_i |=> !done_o && !irq_o);
  p_cmd_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_load_i && !done_pulse_i |=> !done_o && !err_flag_o && !side);
endmodule

bind silo_status silo_status_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk_i, .rst_ni, .cmd_load_i, .ld_status_i, .ld_header_i, .status_word_i,
  .rd_byte_i, .done_pulse_i, .skip_done_i, .done_o, .err_flag_o, .irq_o,
  .side (side), .ent (ent)
);

// File: tb/sim_silo_status.sv
`timescale 1ns/1ps
module sim_silo_status;
  logic clk = 0, rst_ni = 0;
  logic cmd_load_i = 0, ld_status_i = 0, ld_header_i = 0, rd_byte_i = 0;
  logic done_pulse_i = 0, skip_done_i = 0, skip_err_i = 0, drive_ready_i = 0;
  logic [11:0] cmd_word_i = 0, done_err_i = 0;
  logic [15:0] status_word_i = 0;
  logic [8:0]  cyl_i = 0;
  logic        head_i = 0;
  logic [5:0]  sector_i = 0;
  logic [7:0]  rd_byte_o;
  logic        skip_done_o, skip_err_o, done_o, err_flag_o, irq_o;
  logic [11:0] err_rd_o;

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [15:0] m_ent [3];
  logic m_side, m_done, m_ef, m_ie;
  logic [11:0] m_err;

  always #10 clk = ~clk;

  silo_status u0 (.clk_i(clk), .*);

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_err_rd(input logic [11:0] r, input logic rdy);
    return (r & 12'o7002) | {11'd0, rdy};
  endfunction

  task automatic check_state(input string tag);
    chk({15'd0, done_o}, {15'd0, m_done}, {tag, " done R6"});
    chk({15'd0, err_flag_o}, {15'd0, m_ef}, {tag, " errflag R9"});
    chk({15'd0, irq_o}, {15'd0, m_done & m_ie}, {tag, " irq R7"});
    chk({4'd0, err_rd_o}, {4'd0, exp_err_rd(m_err, drive_ready_i)}, {tag, " err_rd R11"});
  endtask

  task automatic finish_op(input string tag);
    @(posedge clk); #1;
    {cmd_load_i, ld_status_i, ld_header_i, rd_byte_i} = 0;
    {done_pulse_i, skip_done_i, skip_err_i} = 0;
    @(negedge clk);
    check_state(tag);
  endtask

  task automatic op_status(input logic [15:0] w);
    status_word_i = w; ld_status_i = 1;
    for (int i = 0; i < 3; i++) m_ent[i] = w;
    finish_op("status R4");
  endtask

  task automatic op_header(input logic [8:0] c, input logic h, input logic [5:0] s);
    cyl_i = c; head_i = h; sector_i = s; ld_header_i = 1;
    m_ent[0] = (16'({c, 1'b0} + h) << 6) | 16'(s);
    m_ent[1] = 0; m_ent[2] = 0;
    finish_op("header R5");
  endtask

  task automatic op_read();
    logic [7:0] e;
    rd_byte_i = 1; #2;
    e = m_side ? m_ent[0][15:8] : m_ent[0][7:0];
    chk({8'd0, rd_byte_o}, {8'd0, e}, m_side ? "high byte R2" : "low byte R1 R3");
    if (m_side) begin m_ent[0] = m_ent[1]; m_ent[1] = m_ent[2]; end
    m_side = ~m_side;
    finish_op("read");
  endtask

  task automatic op_done(input logic [11:0] bits);
    done_err_i = bits; done_pulse_i = 1;
    m_done = 1; m_err |= bits; m_ef = (m_err != 0);
    finish_op("completion R6");
  endtask

  task automatic op_cmd(input logic [11:0] w);
    cmd_word_i = w; cmd_load_i = 1;
    m_done = 0; m_err = 0; m_ef = 0; m_side = 0; m_ie = w[8];
    finish_op("cmd R10");
  endtask

  task automatic op_skd();
    skip_done_i = 1; #2;
    chk({15'd0, skip_done_o}, {15'd0, m_done}, "skip_done R8");
    m_done = 0;
    finish_op("skipdone R8");
  endtask

  task automatic op_ske();
    skip_err_i = 1; #2;
    chk({15'd0, skip_err_o}, {15'd0, m_ef}, "skip_err R9");
    m_ef = 0;
    finish_op("skiperr R9");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) m_ent[i] = 0;
    m_side = 0; m_done = 0; m_ef = 0; m_ie = 0; m_err = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R12 reset state
    check_state("reset R12");
    rd_byte_i = 1; #2;
    chk({8'd0, rd_byte_o}, 16'd0, "reset entry R12");
    finish_op("reset read R12"); m_side = 1;
    op_cmd(12'h100);
    // R4 + R2 tail repeat: 8 reads over a 3-deep queue
    op_status(16'hA55C);
    for (int i = 0; i < 8; i++) op_read();
    // R5 header packing, then zeros behind it
    op_header(9'h1FF, 1'b1, 6'd39);
    for (int i = 0; i < 6; i++) op_read();
    op_header(9'h003, 1'b0, 6'd5);
    op_read();
    op_cmd(12'h000);  // R3 pointer cleared mid-word
    op_read(); op_read();
    // R6/R9 sticky register feeds flag again after skip
    op_done(12'o4000);
    op_ske(); op_ske();
    op_done(12'd0);
    op_skd(); op_skd();
    // R7 enable
    op_cmd(12'h100); op_done(12'd0); op_skd();
    op_cmd(12'h000); op_done(12'o0002);
    drive_ready_i = 1; op_done(12'o0771);
    for (int n = 0; n < 3000; n++) begin
      int k;
      drive_ready_i = $urandom_range(0, 1);
      k = $urandom_range(0, 13);
      case (k)
        0:       op_status(16'($urandom));
        1:       op_header(9'($urandom), 1'($urandom), 6'($urandom));
        2, 3, 4, 5, 6: op_read();
        7:       op_done(($urandom_range(0, 1) != 0) ? 12'($urandom) : 12'd0);
        8:       op_cmd(12'($urandom));
        9, 10:   op_skd();
        11, 12:  op_ske();
        default: op_done(12'd0);
      endcase
    end
    summary();
  end
endmodule